// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, every clock cycle, which one of eight hardware threads may use the single instruction-cache fetch port. Each thread reports whether it is currently active and how many instructions its fetch buffer holds. A thread is also passed the slot index of its next fetch address inside the current 32-byte cache line. A thread drops out of contention while a dependency stall, a cache miss or a long-latency operation holds it inactive. It also drops out while its buffer is full. The thread granted longest ago among the remaining ones wins.

With the grant the block reports how many instructions to read. This is at most four. It never exceeds the free buffer space. It never crosses the end of the 32-byte line of 4-byte instructions. The aim is to keep every thread's buffer topped up. Fetch runs apart from the later pick stage, which drains the buffers.

Grant, valid and count are combinational in the current inputs and the stored age order. The age order itself changes only at the rising clock edge that follows a grant.

Top module: `fetch_thread_sel`

## Requirements
- R1: Out of reset the age order is thread 0 oldest through thread 7 newest. With all threads eligible, the first grant goes to thread 0.
- R2: `fetch_grant` has at most one bit set. When `fetch_valid` is 1, exactly one bit is set.
- R3: A thread whose `thr_active` bit is 0 is never granted.
- R4: A thread whose buffer is full is never granted. A buffer is full when its occupancy, the unsigned field `buf_occ[4k+3:4k]`, is 8 or more.
- R5: Among the eligible threads, the grant goes to the one whose most recent grant lies furthest back.
- R6: `fetch_count` equals the smallest of three values: 4, the granted thread's free slots (8 minus occupancy), and 8 minus its line slot. The line slot is `line_slot[3k+2:3k]`, the 4-byte instruction index within the 32-byte line.
- R7: After a grant only the granted thread becomes newest in the age order. All other threads keep their relative order.
- R8: When no thread is eligible, `fetch_valid` is 0 and `fetch_grant` is all zeros. The age order is left unchanged.
- R9: The outputs follow the inputs within the same cycle. The effect of a grant on the age order shows from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_active | input | 8 | Per-thread active flag |
| buf_occ | input | 32 | Per-thread buffer occupancy, 4 bits per thread |
| line_slot | input | 24 | Per-thread instruction slot within the line, 3 bits per thread |
| fetch_grant | output | 8 | One-hot fetch grant |
| fetch_valid | output | 1 | A thread is granted this cycle |
| fetch_count | output | 3 | Number of instructions to fetch |

## Verification
Grant, valid and count are due in the same cycle as the inputs that cause them. The bench therefore drives inputs at the falling edge and compares 2 ns later, before the next rising edge. A grant's effect on the age order is due one rising edge later. The bench's own age list is updated after each comparison, so the next vector is predicted from the new order. Idle vectors leave that list untouched. The vector that follows them confirms that the design's order held as well.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int unsigned THREADS_DEF     = 8;
  localparam int unsigned BUF_DEPTH_DEF   = 8;
  localparam int unsigned MAX_FETCH_DEF   = 4;
  localparam int unsigned LINE_BYTES_DEF  = 32;
  localparam int unsigned INSTR_BYTES_DEF = 4;

  // free entries in a buffer of the given depth
  function automatic int unsigned free_slots(int unsigned occ, int unsigned depth);
    return (occ >= depth) ? 0 : depth - occ;
  endfunction

  function automatic int unsigned min3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

  // instructions to request: fetch width, buffer room, room left in line
  function automatic int unsigned fetch_len(int unsigned free, int unsigned slot,
                                            int unsigned line_slots, int unsigned maxf);
    return min3(maxf, free, line_slots - slot);
  endfunction
endpackage

// File: rtl/fts_elig.sv
module fts_elig #(
  parameter int unsigned NT         = 8,
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned MAXF       = 4,
  parameter int unsigned LINE_SLOTS = 8,
  parameter int unsigned OCC_W      = 4,
  parameter int unsigned OFF_W      = 3,
  parameter int unsigned CNT_W      = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NT-1:0]       active,
  input  logic [NT*OCC_W-1:0] occ_flat,
  input  logic [NT*OFF_W-1:0] slot_flat,
  output logic [NT-1:0]       elig,
  output logic [NT*CNT_W-1:0] cnt_flat
);
  logic [NT-1:0] has_room;

  for (genvar k = 0; k < NT; k++) begin : g_thr
    logic [OCC_W-1:0] occ_k;
    logic [OFF_W-1:0] slot_k;
    logic [OCC_W-1:0] free_k;
    logic [CNT_W-1:0] cnt_k;

    assign occ_k   = occ_flat[k*OCC_W +: OCC_W];
    assign slot_k  = slot_flat[k*OFF_W +: OFF_W];
    assign free_k  = OCC_W'(fts_pkg::free_slots(32'(occ_k), DEPTH));
    assign has_room[k] = (free_k != '0);
    assign elig[k] = active[k] & has_room[k];
    assign cnt_k   = CNT_W'(fts_pkg::fetch_len(32'(free_k), 32'(slot_k), LINE_SLOTS, MAXF));
    assign cnt_flat[k*CNT_W +: CNT_W] = cnt_k;

    // R6: a request never overfills the buffer
    a_r6_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
      elig[k] |-> (32'(cnt_k) <= 32'(free_k)));
    // R4: full buffer makes the thread ineligible
    a_r4_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(occ_k) >= DEPTH) |-> !elig[k]);
  end
endmodule

// File: rtl/fts_age_matrix.sv
module fts_age_matrix #(
  parameter int unsigned NT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] elig,
  output logic [NT-1:0] grant
);
  // older_q[i][j] = 1 : thread i was granted less recently than thread j
  logic [NT-1:0][NT-1:0] older_q;
  logic [NT-1:0][NT-1:0] beats;
  logic                  any_elig;

  assign any_elig = |elig;

  for (genvar i = 0; i < NT; i++) begin : g_row
    for (genvar j = 0; j < NT; j++) begin : g_col
      if (i == j) begin : g_diag
        assign beats[i][j] = 1'b1;
      end else begin : g_off
        assign beats[i][j] = ~elig[j] | older_q[i][j];
      end
    end
    assign grant[i] = elig[i] & (&beats[i]);

    // R7: the granted thread becomes newest
    a_r7_newest: assert property (@(posedge clk) disable iff (!rst_n)
      grant[i] |=> (older_q[i] == '0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++)
        for (int j = 0; j < NT; j++)
          older_q[i][j] <= (i < j);
    end else if (any_elig) begin
      for (int i = 0; i < NT; i++)
        for (int j = 0; j < NT; j++)
          if (i != j) begin
            if (grant[i])      older_q[i][j] <= 1'b0;
            else if (grant[j]) older_q[i][j] <= 1'b1;
          end
    end
  end

  // R2: never more than one winner
  a_r2_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R8: age order holds when nobody is eligible
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !any_elig |=> $stable(older_q));
endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel #(
  parameter int unsigned NT          = fts_pkg::THREADS_DEF,
  parameter int unsigned DEPTH       = fts_pkg::BUF_DEPTH_DEF,
  parameter int unsigned MAXF        = fts_pkg::MAX_FETCH_DEF,
  parameter int unsigned LINE_BYTES  = fts_pkg::LINE_BYTES_DEF,
  parameter int unsigned INSTR_BYTES = fts_pkg::INSTR_BYTES_DEF,
  localparam int unsigned LINE_SLOTS = LINE_BYTES / INSTR_BYTES,
  localparam int unsigned OCC_W      = $clog2(DEPTH + 1),
  localparam int unsigned OFF_W      = $clog2(LINE_SLOTS),
  localparam int unsigned CNT_W      = $clog2(MAXF + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NT-1:0]       thr_active,
  input  logic [NT*OCC_W-1:0] buf_occ,
  input  logic [NT*OFF_W-1:0] line_slot,
  output logic [NT-1:0]       fetch_grant,
  output logic                fetch_valid,
  output logic [CNT_W-1:0]    fetch_count
);
  logic [NT-1:0]       elig;
  logic [NT*CNT_W-1:0] cnt_all;
  logic [CNT_W-1:0]    cnt_sel;

  fts_elig #(
    .NT(NT), .DEPTH(DEPTH), .MAXF(MAXF), .LINE_SLOTS(LINE_SLOTS),
    .OCC_W(OCC_W), .OFF_W(OFF_W), .CNT_W(CNT_W)
  ) u_elig (
    .clk(clk), .rst_n(rst_n), .active(thr_active), .occ_flat(buf_occ),
    .slot_flat(line_slot), .elig(elig), .cnt_flat(cnt_all)
  );

  fts_age_matrix #(.NT(NT)) u_age (
    .clk(clk), .rst_n(rst_n), .elig(elig), .grant(fetch_grant)
  );

  always_comb begin
    cnt_sel = '0;
    for (int i = 0; i < NT; i++)
      if (fetch_grant[i]) cnt_sel = cnt_sel | cnt_all[i*CNT_W +: CNT_W];
  end

  assign fetch_valid = |elig;
  assign fetch_count = cnt_sel;

  // R2: a valid cycle carries exactly one grant
  a_r2_valid_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> $onehot(fetch_grant));
  // R3: inactive threads are never granted
  a_r3_active_only: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_grant & ~thr_active) == '0);
  // R8: idle cycle carries no grant
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> (fetch_grant == '0));
  // R6: count within 1..MAXF on a grant
  a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> (fetch_count != '0 && 32'(fetch_count) <= MAXF));
endmodule

// File: tb/fetch_thread_sel_test.sv
module fetch_thread_sel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  thr_active = '0;
  logic [31:0] buf_occ = '0;
  logic [23:0] line_slot = '0;
  logic [7:0]  fetch_grant;
  logic        fetch_valid;
  logic [2:0]  fetch_count;

  int n_vec = 0;
  int n_bad = 0;
  int ord[8];   // ord[0] = least recently granted

  always #4 clk = ~clk;   // 125 MHz

  fetch_thread_sel uut (
    .clk(clk), .rst_n(rst_n), .thr_active(thr_active), .buf_occ(buf_occ),
    .line_slot(line_slot), .fetch_grant(fetch_grant),
    .fetch_valid(fetch_valid), .fetch_count(fetch_count)
  );

  function automatic bit may_fetch(int t);
    return thr_active[t] && (buf_occ[t*4 +: 4] < 4'd8);
  endfunction

  function automatic int want_count(int t);
    int c;
    c = 4;
    if (8 - int'(buf_occ[t*4 +: 4]) < c) c = 8 - int'(buf_occ[t*4 +: 4]);
    if (8 - int'(line_slot[t*3 +: 3]) < c) c = 8 - int'(line_slot[t*3 +: 3]);
    return c;
  endfunction

  function automatic int pick_model();
    for (int p = 0; p < 8; p++) if (may_fetch(ord[p])) return ord[p];
    return -1;
  endfunction

  task automatic promote(int t);
    int pos;
    pos = 0;
    for (int p = 0; p < 8; p++) if (ord[p] == t) pos = p;
    for (int p = pos; p < 7; p++) ord[p] = ord[p+1];
    ord[7] = t;
  endtask

  task automatic apply(input logic [7:0] a, input logic [31:0] o,
                       input logic [23:0] s, input string req);
    int w;
    logic [7:0] eg;
    logic ev;
    logic [2:0] ec;
    @(negedge clk);
    thr_active = a; buf_occ = o; line_slot = s;
    #2;
    w  = pick_model();
    ev = (w >= 0);
    eg = ev ? (8'd1 << w) : 8'd0;
    ec = ev ? 3'(want_count(w)) : 3'd0;
    n_vec++;
    if (fetch_grant !== eg || fetch_valid !== ev || (ev && fetch_count !== ec)) begin
      n_bad++;
      $display("FAIL %s: grant=%b valid=%b count=%0d expected grant=%b valid=%b count=%0d",
               req, fetch_grant, fetch_valid, fetch_count, eg, ev, ec);
    end
    if (ev) promote(w);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0]  ra;
    logic [31:0] ro;
    logic [23:0] rs;
    int unsigned seed;
    for (int t = 0; t < 8; t++) ord[t] = t;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R8: reset state, nothing active
    apply(8'h00, '0, '0, "R8 reset idle");
    // R1: thread 0 first, then the rest in order
    for (int k = 0; k < 8; k++) apply(8'hFF, '0, '0, "R1 reset order");
    // R3: only thread 5 active
    apply(8'h20, '0, '0, "R3 single active");
    // R4: all full except thread 2
    apply(8'hFF, 32'h8888_8988 & ~32'h0000_0F00 | 32'h0000_0300, '0, "R4 full buffers");
    // R4: everyone full -> idle
    apply(8'hFF, 32'h8888_8888, '0, "R4 R8 all full");
    // R8 R7: order held across idle cycles
    apply(8'h00, '0, '0, "R8 idle hold");
    apply(8'hFF, '0, '0, "R8 order after idle");
    // R6: line end clipping, slot 6 -> 2 instructions
    apply(8'hFF, '0, {8{3'd6}}, "R6 line end");
    // R6: one free slot
    apply(8'hFF, {8{4'd7}}, '0, "R6 one free");
    // R6: slot 7 -> 1 instruction
    apply(8'hFF, '0, {8{3'd7}}, "R6 last slot");
    // R5 R7: two threads alternate
    for (int k = 0; k < 4; k++) apply(8'h41, '0, '0, "R5 alternate");
    seed = 32'd1234;
    void'($urandom(seed));
    for (int k = 0; k < 3000; k++) begin
      ra = 8'($urandom);
      ro = '0;
      for (int t = 0; t < 8; t++) ro[t*4 +: 4] = 4'($urandom_range(0, 9));
      rs = 24'($urandom);
      if (k % 97 == 0) ra = 8'h00;
      apply(ra, ro, rs, "R5 R6 R7 R9 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule